// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog counter managed through a single 16-bit control word on a simple register port. Every write must carry a fixed key in its upper byte. A write with any other key byte is treated as a software fault and raises a system reset request at once. Reads return a different fixed key in the upper byte, so a value that was read back cannot be written again without change and pass the key check.

The counter advances on one of two clock-enable strobes, which stand in for a fast and a slow clock source. Its expiry point is a power-of-two tap chosen by a 2-bit code. In watchdog mode, expiry raises a one-cycle reset request. In interval mode, expiry sets a sticky interrupt flag, and that flag is gated by an enable to form the interrupt request.

Every reset request, whether from a bad key or from an expiry, returns the control word and the counter to their power-up state. That state is armed, in watchdog mode, on the longest tap. Software must therefore reprogram the block or hold it before the first expiry. Two further control bits only select how an external non-maskable pin is handled, and the block passes them straight out.

Top module: `wdt_guard`

## Requirements
- R1: After rst_n is released, rd_data reads 0x6900, and rst_req, irq_flag and irq_req are all 0.
- R2: rd_data always shows 0x69 in bits 15:8 and 0 in bit 3. Bits 7:4 and 2:0 show the stored control fields.
- R3: A write whose bits 15:8 equal 0x5A stores bit 7 (hold), bit 6 (NMI falling edge), bit 5 (NMI function), bit 4 (1 = interval mode), bit 2 (1 = slow strobe) and bits 1:0 (tap code). The new value is readable from the cycle after the write.
- R4: A write whose key byte is not 0x5A raises rst_req for exactly one cycle, starting the cycle after the write, and rd_data returns to 0x6900.
- R5: While the hold bit is 1, the counter does not advance. When the hold bit is cleared without a counter clear, counting resumes from the held value.
- R6: A keyed write with bit 3 set zeroes the counter. A strobe in that same cycle is not counted.
- R7: With bit 2 = 0 only fast_tick advances the counter. With bit 2 = 1 only slow_tick advances it.
- R8: Counting from zero, expiry occurs on strobe number 32768, 8192, 512 or 64 for tap code 00, 01, 10 or 11.
- R9: In watchdog mode, expiry raises rst_req for one cycle and restores rd_data to 0x6900. From power-up this happens after 32768 fast strobes.
- R10: In interval mode, expiry sets irq_flag and never raises rst_req. Counting continues, so the flag is set again every interval.
- R11: irq_flag stays set until an irq_clr cycle or a reset request, and a set in the same cycle wins over irq_clr. irq_req is 1 exactly when irq_flag and irq_en are both 1.
- R12: nmi_falling follows stored bit 6 and nmi_select follows stored bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word; key in bits 15:8 |
| rd_data | output | 16 | Read word; read key in bits 15:8 |
| fast_tick | input | 1 | Count enable from the fast source |
| slow_tick | input | 1 | Count enable from the slow source |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky interval-expiry flag |
| irq_req | output | 1 | Flag gated by the enable |
| rst_req | output | 1 | One-cycle system reset request |
| nmi_falling | output | 1 | NMI edge choice, 1 = falling |
| nmi_select | output | 1 | Pin function, 1 = NMI, 0 = reset |

## Verification
Configuration is registered, so a write is readable, and a bad key shows on rst_req, after the first clock edge that follows the write cycle. The bench samples on the falling edge after that rising edge. Expiry is registered on the edge that counts the final strobe. The bench drives one strobe per cycle from the falling edge after the configuring write and counts falling edges until the event appears, so the count must equal the tap length exactly. A counter clear issued mid-interval must restart that count at the write. A held counter must let nothing through for a long window.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

   localparam logic [7:0] WR_KEY = 8'h5A;
   localparam logic [7:0] RD_KEY = 8'h69;

   localparam int B_HOLD  = 7;
   localparam int B_NFALL = 6;
   localparam int B_NMODE = 5;
   localparam int B_TMODE = 4;
   localparam int B_CLR   = 3;
   localparam int B_CSEL  = 2;

   typedef struct packed {
      logic       hold;
      logic       nmi_fall;
      logic       nmi_mode;
      logic       tmr_mode;
      logic       clk_sel;
      logic [1:0] tap_sel;
   } wdt_cfg_t;

   localparam wdt_cfg_t CFG_DEFAULT = '0;

   function automatic wdt_cfg_t cfg_from_byte(input logic [7:0] b);
      wdt_cfg_t c;
      c.hold     = b[B_HOLD];
      c.nmi_fall = b[B_NFALL];
      c.nmi_mode = b[B_NMODE];
      c.tmr_mode = b[B_TMODE];
      c.clk_sel  = b[B_CSEL];
      c.tap_sel  = b[1:0];
      return c;
   endfunction

   function automatic logic [7:0] cfg_to_byte(input wdt_cfg_t c);
      return {c.hold, c.nmi_fall, c.nmi_mode, c.tmr_mode, 1'b0, c.clk_sel, c.tap_sel};
   endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
   import wdt_guard_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   input  logic        force_dflt,
   output wdt_cfg_t    cfg,
   output logic        key_bad,
   output logic        clr_pulse
);

   logic wr_ok;

   always_comb begin
      key_bad   = wr_en && (wr_data[15:8] != WR_KEY);
      wr_ok     = wr_en && (wr_data[15:8] == WR_KEY);
      clr_pulse = wr_ok && wr_data[B_CLR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= CFG_DEFAULT;
      else if (force_dflt)
         cfg <= CFG_DEFAULT;
      else if (wr_ok)
         cfg <= cfg_from_byte(wr_data[7:0]);
   end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int TAP_CODE0 = 15,
   parameter int TAP_CODE1 = 13,
   parameter int TAP_CODE2 = 9,
   parameter int TAP_CODE3 = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fast_tick,
   input  logic       slow_tick,
   input  logic       clk_sel,
   input  logic       hold,
   input  logic [1:0] tap_sel,
   input  logic       clr,
   input  logic       force_dflt,
   output logic       expire
);

   localparam int MAX_A = (TAP_CODE0 > TAP_CODE1) ? TAP_CODE0 : TAP_CODE1;
   localparam int MAX_B = (TAP_CODE2 > TAP_CODE3) ? TAP_CODE2 : TAP_CODE3;
   localparam int CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int N_TAP = 4;

   function automatic int tap_of(input int g);
      case (g)
         0:       return TAP_CODE0;
         1:       return TAP_CODE1;
         2:       return TAP_CODE2;
         default: return TAP_CODE3;
      endcase
   endfunction

   generate
      if (TAP_CODE0 < 1 || TAP_CODE1 < 1 || TAP_CODE2 < 1 || TAP_CODE3 < 1) begin : g_bad_tap
         $error("wdt_count: every tap must be at least 1");
      end
      if (CNT_W > 31) begin : g_bad_width
         $error("wdt_count: tap too wide");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [N_TAP-1:0] hit;
   logic             tick_en;

   generate
      for (genvar g = 0; g < N_TAP; g++) begin : g_tap
         localparam int W = tap_of(g);
         assign hit[g] = &cnt[W-1:0];
      end
   endgenerate

   always_comb begin
      tick_en = !hold && (clk_sel ? slow_tick : fast_tick);
      expire  = tick_en && !clr && hit[tap_sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (force_dflt || clr)
         cnt <= '0;
      else if (tick_en)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/wdt_event.sv
module wdt_event (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic tmr_mode,
   input  logic key_bad,
   input  logic irq_clr,
   output logic wd_expire,
   output logic rst_req,
   output logic irq_flag
);

   logic fault;

   always_comb begin
      wd_expire = expire && !tmr_mode;
      fault     = key_bad || wd_expire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rst_req <= 1'b0;
      else
         rst_req <= fault;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_flag <= 1'b0;
      else if (fault)
         irq_flag <= 1'b0;
      else if (expire && tmr_mode)
         irq_flag <= 1'b1;
      else if (irq_clr)
         irq_flag <= 1'b0;
   end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int TAP_CODE0 = 15,
   parameter int TAP_CODE1 = 13,
   parameter int TAP_CODE2 = 9,
   parameter int TAP_CODE3 = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   input  logic        fast_tick,
   input  logic        slow_tick,
   input  logic        irq_en,
   input  logic        irq_clr,
   output logic        irq_flag,
   output logic        irq_req,
   output logic        rst_req,
   output logic        nmi_falling,
   output logic        nmi_select
);

   wdt_cfg_t cfg;
   logic     key_bad;
   logic     clr_pulse;
   logic     expire;
   logic     wd_expire;
   logic     force_dflt;

   assign force_dflt = key_bad || wd_expire;

   wdt_cfg_reg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .force_dflt (force_dflt),
      .cfg        (cfg),
      .key_bad    (key_bad),
      .clr_pulse  (clr_pulse)
   );

   wdt_count #(
      .TAP_CODE0 (TAP_CODE0),
      .TAP_CODE1 (TAP_CODE1),
      .TAP_CODE2 (TAP_CODE2),
      .TAP_CODE3 (TAP_CODE3)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_tick  (fast_tick),
      .slow_tick  (slow_tick),
      .clk_sel    (cfg.clk_sel),
      .hold       (cfg.hold),
      .tap_sel    (cfg.tap_sel),
      .clr        (clr_pulse),
      .force_dflt (force_dflt),
      .expire     (expire)
   );

   wdt_event u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .tmr_mode  (cfg.tmr_mode),
      .key_bad   (key_bad),
      .irq_clr   (irq_clr),
      .wd_expire (wd_expire),
      .rst_req   (rst_req),
      .irq_flag  (irq_flag)
   );

   always_comb begin
      rd_data     = {RD_KEY, cfg_to_byte(cfg)};
      irq_req     = irq_flag && irq_en;
      nmi_falling = cfg.nmi_fall;
      nmi_select  = cfg.nmi_mode;
   end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic [15:0] rd_data,
   input logic        irq_clr,
   input logic        irq_flag,
   input logic        rst_req
);

   p_read_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[15:8] == 8'h69) && !rd_data[3]);

   p_keyed_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[15:8] == 8'h5A) |=>
         (rst_req || rd_data[7:0] == ($past(wr_data[7:0]) & 8'hF7)));

   p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[15:8] != 8'h5A) |=> rst_req);

   p_reset_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (rd_data == 16'h6900));

   p_interval_no_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[4] && !wr_en) |=> !rst_req);

   p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> (irq_flag || rst_req));

endmodule

bind wdt_guard wdt_guard_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .irq_clr  (irq_clr),
   .irq_flag (irq_flag),
   .rst_req  (rst_req)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        fast_tick = 1'b0;
   logic        slow_tick = 1'b0;
   logic        irq_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic        irq_flag, irq_req, rst_req, nmi_falling, nmi_select;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   wdt_guard dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .fast_tick   (fast_tick),
      .slow_tick   (slow_tick),
      .irq_en      (irq_en),
      .irq_clr     (irq_clr),
      .irq_flag    (irq_flag),
      .irq_req     (irq_req),
      .rst_req     (rst_req),
      .nmi_falling (nmi_falling),
      .nmi_select  (nmi_select)
   );

   // write word, expected read word, expected reset request
   localparam int NV = 10;
   localparam logic [32:0] VEC [NV] = '{
      {16'h5A80, 16'h6980, 1'b0},
      {16'h5AF7, 16'h69F7, 1'b0},
      {16'h5A88, 16'h6980, 1'b0},
      {16'h5AE4, 16'h69E4, 1'b0},
      {16'h5AD5, 16'h69D5, 1'b0},
      {16'h5A80, 16'h6980, 1'b0},
      {16'h1280, 16'h6900, 1'b1},
      {16'h5AA6, 16'h69A6, 1'b0},
      {16'hA580, 16'h6900, 1'b1},
      {16'h5A80, 16'h6980, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] w);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   task automatic run_until(input bit want_rst, input int limit, output int n);
      n = 0;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (want_rst ? rst_req : irq_flag) break;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 190000);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int n;
      do_reset();
      // R1 reset state
      chk("R1 rd", rd_data, 16'h6900);
      chk("R1 rst", rst_req, 0);
      chk("R1 flag", irq_flag, 0);
      chk("R1 req", irq_req, 0);

      // R2 R3 R4 vector table
      for (int i = 0; i < NV; i++) begin
         do_write(VEC[i][32:17]);
         chk("R3 R2 table rd", rd_data, VEC[i][16:1]);
         chk("R4 table rst", rst_req, VEC[i][0]);
         if (VEC[i][0]) begin
            @(negedge clk);
            chk("R4 single pulse", rst_req, 0);
         end
      end

      // R9 power-up expiry on longest tap
      do_reset();
      fast_tick = 1'b1;
      run_until(1'b1, 40000, n);
      chk("R9 R8 power-up expiry", n, 32768);
      chk("R9 defaults restored", rd_data, 16'h6900);
      @(negedge clk);
      chk("R9 pulse width", rst_req, 0);
      fast_tick = 1'b0;

      // R8 R9 watchdog mode short tap
      do_write(16'h5A0B);
      fast_tick = 1'b1;
      run_until(1'b1, 1000, n);
      chk("R9 R8 tap 11 reset", n, 64);
      fast_tick = 1'b0;

      // R10 interval mode tap 10, then periodic
      do_write(16'h5A1A);
      fast_tick = 1'b1;
      run_until(1'b0, 2000, n);
      chk("R10 R8 tap 10 flag", n, 512);
      chk("R10 no reset", rst_req, 0);
      irq_en = 1'b0;
      #1;
      chk("R11 req gated off", irq_req, 0);
      irq_en = 1'b1;
      #1;
      chk("R11 req on", irq_req, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R11 flag cleared", irq_flag, 0);
      run_until(1'b0, 2000, n);
      chk("R10 periodic", n + 1, 512);
      fast_tick = 1'b0;

      // R7 R8 slow strobe, tap 01
      clear_flag();
      do_write(16'h5A1D);
      slow_tick = 1'b1;
      run_until(1'b0, 10000, n);
      chk("R7 R8 slow tap 01", n, 8192);
      slow_tick = 1'b0;

      // R7 fast strobe ignored when slow selected
      clear_flag();
      do_write(16'h5A1F);
      fast_tick = 1'b1;
      repeat (200) @(negedge clk);
      chk("R7 fast ignored", irq_flag, 0);
      fast_tick = 1'b0;

      // R8 tap 00 in interval mode
      do_write(16'h5A18);
      fast_tick = 1'b1;
      run_until(1'b0, 40000, n);
      chk("R8 tap 00", n, 32768);
      fast_tick = 1'b0;

      // R5 hold stops counting, resume without clear
      clear_flag();
      do_write(16'h5A9B);
      fast_tick = 1'b1;
      repeat (200) @(negedge clk);
      chk("R5 held", irq_flag, 0);
      do_write(16'h5A13);
      run_until(1'b0, 1000, n);
      chk("R5 resume", n, 64);
      fast_tick = 1'b0;

      // R6 clear restarts interval
      clear_flag();
      do_write(16'h5A1B);
      fast_tick = 1'b1;
      repeat (40) @(negedge clk);
      chk("R6 before clear", irq_flag, 0);
      do_write(16'h5A1B);
      run_until(1'b0, 1000, n);
      chk("R6 restart", n, 64);
      fast_tick = 1'b0;

      // R12 NMI select outputs
      do_write(16'h5AE0);
      chk("R12 edge", nmi_falling, 1);
      chk("R12 func", nmi_select, 1);
      do_write(16'h5AC0);
      chk("R12 edge b", nmi_falling, 1);
      chk("R12 func b", nmi_select, 0);
      do_write(16'h5AA0);
      chk("R12 edge c", nmi_falling, 0);
      chk("R12 func c", nmi_select, 1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule